// File: doc/BRIEF.md
# Address Translation Buffer with Instruction-Side Refill

This block translates 32-bit virtual addresses into 29-bit physical addresses. It holds a large unified table, 64 entries by default, for data accesses, and a small four-entry table for instruction fetches. Every valid entry is compared in parallel against the incoming address. The compare honours a per-entry page size of 1 KB, 4 KB, 64 KB or 1 MB, an 8-bit address-space tag and a shared flag. The block reports a single hit with its index and physical address, a miss, or a multiple hit.

An instruction fetch that misses the small table but hits exactly one entry of the unified table is answered from the unified entry in the same cycle. At the next rising edge that entry is copied into the small table. The slot it replaces is the least recently used one, tracked by six pairwise-order bits.

Software fills the unified table one entry at a time. Each write lands at the slot named by a replacement counter. That counter advances on every unified-table search and wraps at a programmable bound. A global invalidate input empties both tables in one cycle.

Top module: `tlb_unit`

## Requirements
- R1: An entry whose valid bit is 0 never matches. After reset every valid bit is 0, the replacement counter is 0 and the order bits are 000000.
- R2: The tag compare is active when `cfg_sv` is 0 or `cfg_md` is 0. While it is active, an entry with `sh`=0 matches only if its tag equals `cur_asid`. An entry with `sh`=1 matches regardless of the tag.
- R3: Size code 0, 1, 2 and 3 selects a page of 1 KB, 4 KB, 64 KB and 1 MB. An entry matches when the address bits above the page offset equal `{vpn,10'b0}` with its offset bits cleared. The physical address is `{ppn,10'b0}` with its offset bits cleared, ORed with the offset bits of the virtual address.
- R4: When two or more valid entries match a data lookup, `d_multi` is 1 and `d_hit` is 0. Otherwise `d_idx` is the index of the matching entry.
- R5: Consider an instruction lookup that misses the small table and hits exactly one unified entry. In that cycle `i_fill` is 1, `i_idx` names the victim slot, and `i_paddr`/`i_attr` come from the unified entry. From the next edge on, the slot holds a copy of that entry, so a repeat of the lookup gives `i_hit`=1.
- R6: The order bits are L[5:0] on `lru`. The victim is chosen by the first of these rules that applies:
  - L5,L4,L3 all 1 selects slot 0;
  - L5=0, L2=1 and L1=1 selects slot 1;
  - L4=0, L2=0 and L0=1 selects slot 2;
  - L3, L2 and L0 all 0 selects slot 3.
- R7: A hit or a fill on a slot updates the order bits at the next edge, and leaves the other bits unchanged:
  - slot 0 clears L5, L4 and L3;
  - slot 1 sets L5 and clears L2 and L1;
  - slot 2 sets L4 and L2 and clears L0;
  - slot 3 sets L3, L1 and L0.
- R8: The counter `urc` advances by one at each edge after a cycle in which the unified table is searched: `d_req`=1, or `i_req`=1 with no match in the small table. The next value becomes 0 when it would exceed `urb` while `urb` is nonzero, or when it would exceed 63.
- R9: With `load_en`=1, the unified entry indexed by the current `urc` takes the `load_*` fields at the next edge. `load_v` becomes its valid bit.
- R10: With `inv_all`=1, both tables have every valid bit cleared at the next edge. Any load or fill in that same cycle is discarded, and the order bits are not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inv_all | input | 1 | Invalidate every entry of both tables |
| cfg_sv | input | 1 | Supervisor tag-bypass enable |
| cfg_md | input | 1 | Privileged mode (1) or user mode (0) |
| cur_asid | input | 8 | Current address-space tag |
| urb | input | 6 | Counter bound, 0 means no bound |
| load_en | input | 1 | Write one unified entry at `urc` |
| load_vpn | input | 22 | Virtual page number to load |
| load_asid | input | 8 | Tag to load |
| load_ppn | input | 19 | Physical page number to load |
| load_sz | input | 2 | Size code to load |
| load_sh | input | 1 | Shared flag to load |
| load_v | input | 1 | Valid bit to load |
| load_attr | input | 4 | Protection/cache attributes to load |
| d_req | input | 1 | Data lookup request |
| d_addr | input | 32 | Data virtual address |
| d_hit | output | 1 | Single unified hit |
| d_miss | output | 1 | No unified match |
| d_multi | output | 1 | Two or more unified matches |
| d_idx | output | 6 | Index of the matching unified entry |
| d_paddr | output | 29 | Translated data address |
| d_attr | output | 4 | Attributes of the matching entry |
| i_req | input | 1 | Instruction lookup request |
| i_addr | input | 32 | Instruction virtual address |
| i_hit | output | 1 | Single hit in the small table |
| i_fill | output | 1 | Small-table miss answered by the unified table |
| i_miss | output | 1 | No match in either table |
| i_multi | output | 1 | Multiple match in the table consulted |
| i_idx | output | 2 | Hit slot, or victim slot on a fill |
| i_paddr | output | 29 | Translated instruction address |
| i_attr | output | 4 | Attributes of the entry used |
| urc | output | 6 | Unified replacement counter |
| lru | output | 6 | Order bits L[5:0] of the small table |

## Verification
The lookup results (`d_*` and `i_*`) are combinational and are sampled 2 ns after the inputs change at the falling edge, before the next rising edge. The table writes, the counter and the order bits each take effect at the first rising edge after the request. They are read at the following falling edge. The bench therefore checks a fill by repeating the lookup one cycle later, and it advances its own model of `urc` one step per search cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 29;
    localparam int OFS_W  = 10;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int PPN_W  = PA_W - OFS_W;
    localparam int ASID_W = 8;
    localparam int ATTR_W = 4;

    typedef enum logic [1:0] {
        PG_1K  = 2'd0,
        PG_4K  = 2'd1,
        PG_64K = 2'd2,
        PG_1M  = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        pg_size_e          sz;
        logic              sh;
        logic [ATTR_W-1:0] attr;
    } tlb_ent_t;

    // ones on the page-offset bits of a page of the given size
    function automatic logic [VA_W-1:0] ofs_mask(pg_size_e sz);
        case (sz)
            PG_1K:   return 32'h0000_03FF;
            PG_4K:   return 32'h0000_0FFF;
            PG_64K:  return 32'h0000_FFFF;
            default: return 32'h000F_FFFF;
        endcase
    endfunction

    function automatic logic ent_match(tlb_ent_t e, logic [VA_W-1:0] va,
                                       logic chk, logic [ASID_W-1:0] asid);
        logic [VA_W-1:0] m;
        logic            page_eq;
        m       = ofs_mask(e.sz);
        page_eq = ((va ^ {e.vpn, {OFS_W{1'b0}}}) & ~m) == '0;
        return page_eq && (!chk || e.sh || (e.asid == asid));
    endfunction

    function automatic logic [PA_W-1:0] xlate(tlb_ent_t e, logic [VA_W-1:0] va);
        logic [VA_W-1:0] m;
        m = ofs_mask(e.sz);
        return ({e.ppn, {OFS_W{1'b0}}} & ~m[PA_W-1:0]) | (va[PA_W-1:0] & m[PA_W-1:0]);
    endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  tlb_ent_t          ent [N],
    input  logic [N-1:0]      vld,
    input  logic [VA_W-1:0]   va,
    input  logic              chk_asid,
    input  logic [ASID_W-1:0] asid,
    output logic              any,
    output logic              multi,
    output logic [IW-1:0]     idx
);
    // parallel compare; lowest matching index is reported
    always_comb begin
        any   = 1'b0;
        multi = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && ent_match(ent[i], va, chk_asid, asid)) begin
                if (any) multi = 1'b1;
                else     idx   = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/itlb_lru.sv
module itlb_lru (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       touch,
    input  logic [1:0] touch_idx,
    output logic [5:0] lru,
    output logic [1:0] victim
);
    logic [5:0] lru_nxt;

    always_comb begin
        if (lru[5] && lru[4] && lru[3])                 victim = 2'd0;
        else if (!lru[5] && lru[2] && lru[1])           victim = 2'd1;
        else if (!lru[4] && !lru[2] && lru[0])          victim = 2'd2;
        else if (!lru[3] && !lru[2] && !lru[0])         victim = 2'd3;
        else                                            victim = 2'd0;
    end

    always_comb begin
        lru_nxt = lru;
        if (touch) begin
            case (touch_idx)
                2'd0: lru_nxt[5:3] = 3'b000;
                2'd1: begin lru_nxt[5] = 1'b1; lru_nxt[2:1] = 2'b00; end
                2'd2: begin lru_nxt[4] = 1'b1; lru_nxt[2] = 1'b1; lru_nxt[0] = 1'b0; end
                default: begin lru_nxt[3] = 1'b1; lru_nxt[1] = 1'b1; lru_nxt[0] = 1'b1; end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lru <= '0;
        else        lru <= lru_nxt;
    end

    AST_LRU_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (victim != $past(touch_idx)));  // R7
endmodule

// File: rtl/urc_ctr.sv
module urc_ctr #(
    parameter int N = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          access,
    input  logic [IW-1:0] urb,
    output logic [IW-1:0] urc
);
    logic [IW:0] inc;
    logic        wrap;

    always_comb begin
        inc  = {1'b0, urc} + 1'b1;
        wrap = ((urb != '0) && (inc > {1'b0, urb})) || (inc > (IW+1)'(N - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      urc <= '0;
        else if (access) urc <= wrap ? '0 : inc[IW-1:0];
    end

    AST_URC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (access && (urb != '0)) |=> (urc <= $past(urb)));  // R8
    AST_URC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !access |=> $stable(urc));  // R8
endmodule

// File: rtl/tlb_unit.sv
module tlb_unit
    import tlb_pkg::*;
#(
    parameter int UTLB_N = 64,
    localparam int IW     = $clog2(UTLB_N),
    localparam int ITLB_N = 4,
    localparam int IIW    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              cfg_sv,
    input  logic              cfg_md,
    input  logic [7:0]        cur_asid,
    input  logic [IW-1:0]     urb,
    input  logic              load_en,
    input  logic [21:0]       load_vpn,
    input  logic [7:0]        load_asid,
    input  logic [18:0]       load_ppn,
    input  logic [1:0]        load_sz,
    input  logic              load_sh,
    input  logic              load_v,
    input  logic [3:0]        load_attr,
    input  logic              d_req,
    input  logic [31:0]       d_addr,
    output logic              d_hit,
    output logic              d_miss,
    output logic              d_multi,
    output logic [IW-1:0]     d_idx,
    output logic [28:0]       d_paddr,
    output logic [3:0]        d_attr,
    input  logic              i_req,
    input  logic [31:0]       i_addr,
    output logic              i_hit,
    output logic              i_fill,
    output logic              i_miss,
    output logic              i_multi,
    output logic [IIW-1:0]    i_idx,
    output logic [28:0]       i_paddr,
    output logic [3:0]        i_attr,
    output logic [IW-1:0]     urc,
    output logic [5:0]        lru
);
    tlb_ent_t            u_ent [UTLB_N];
    logic [UTLB_N-1:0]   u_vld;
    tlb_ent_t            i_ent [ITLB_N];
    logic [ITLB_N-1:0]   i_vld;

    logic                chk_asid;
    logic                du_any, du_mul, iu_any, iu_mul, it_any, it_mul;
    logic [IW-1:0]       du_idx, iu_idx;
    logic [IIW-1:0]      it_idx, victim;
    logic                u_access, lru_touch;
    tlb_ent_t            i_src, load_ent;

    assign chk_asid = !cfg_sv || !cfg_md;

    tlb_cam #(.N(UTLB_N)) u_cam_d (
        .ent(u_ent), .vld(u_vld), .va(d_addr), .chk_asid(chk_asid), .asid(cur_asid),
        .any(du_any), .multi(du_mul), .idx(du_idx));

    tlb_cam #(.N(UTLB_N)) u_cam_i (
        .ent(u_ent), .vld(u_vld), .va(i_addr), .chk_asid(chk_asid), .asid(cur_asid),
        .any(iu_any), .multi(iu_mul), .idx(iu_idx));

    tlb_cam #(.N(ITLB_N)) i_cam (
        .ent(i_ent), .vld(i_vld), .va(i_addr), .chk_asid(chk_asid), .asid(cur_asid),
        .any(it_any), .multi(it_mul), .idx(it_idx));

    // data side
    assign d_hit   = d_req && du_any && !du_mul;
    assign d_miss  = d_req && !du_any;
    assign d_multi = d_req && du_mul;
    assign d_idx   = du_idx;
    assign d_paddr = xlate(u_ent[du_idx], d_addr);
    assign d_attr  = u_ent[du_idx].attr;

    // instruction side: small table first, unified table on its miss
    assign i_hit   = i_req && it_any && !it_mul;
    assign i_fill  = i_req && !it_any && iu_any && !iu_mul;
    assign i_miss  = i_req && !it_any && !iu_any;
    assign i_multi = i_req && (it_mul || (!it_any && iu_mul));
    assign i_idx   = it_any ? it_idx : victim;
    assign i_src   = it_any ? i_ent[it_idx] : u_ent[iu_idx];
    assign i_paddr = xlate(i_src, i_addr);
    assign i_attr  = i_src.attr;

    assign u_access  = d_req || (i_req && !it_any);
    assign lru_touch = !inv_all && (i_hit || i_fill);

    itlb_lru u_lru (
        .clk(clk), .rst_n(rst_n), .touch(lru_touch),
        .touch_idx(i_hit ? it_idx : victim), .lru(lru), .victim(victim));

    urc_ctr #(.N(UTLB_N)) u_urc (
        .clk(clk), .rst_n(rst_n), .access(u_access), .urb(urb), .urc(urc));

    assign load_ent = '{vpn: load_vpn, asid: load_asid, ppn: load_ppn,
                        sz: pg_size_e'(load_sz), sh: load_sh, attr: load_attr};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_vld <= '0;
            i_vld <= '0;
        end else if (inv_all) begin
            u_vld <= '0;
            i_vld <= '0;
        end else begin
            if (load_en) u_vld[urc]    <= load_v;
            if (i_fill)  i_vld[victim] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!inv_all) begin
            if (load_en) u_ent[urc]    <= load_ent;
            if (i_fill)  i_ent[victim] <= u_ent[iu_idx];
        end
    end

    AST_INV_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> ((u_vld == '0) && (i_vld == '0)));  // R10
    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !inv_all) |=> (u_vld[$past(urc)] == $past(load_v)));  // R9
    AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (i_fill && !inv_all) |=> i_vld[$past(victim)]);  // R5
    AST_FILL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        i_fill |-> !i_hit);  // R5
endmodule

// File: tb/tb_tlb_unit.sv
`timescale 1ns/1ps
module tb_tlb_unit;
    logic        clk = 1'b0;
    logic        rst_n, inv_all, cfg_sv, cfg_md;
    logic [7:0]  cur_asid;
    logic [5:0]  urb;
    logic        load_en, load_sh, load_v;
    logic [21:0] load_vpn;
    logic [7:0]  load_asid;
    logic [18:0] load_ppn;
    logic [1:0]  load_sz;
    logic [3:0]  load_attr;
    logic        d_req, d_hit, d_miss, d_multi;
    logic [31:0] d_addr, i_addr;
    logic [5:0]  d_idx, urc, lru;
    logic [28:0] d_paddr, i_paddr;
    logic [3:0]  d_attr, i_attr;
    logic        i_req, i_hit, i_fill, i_miss, i_multi;
    logic [1:0]  i_idx;

    int n_chk = 0;
    int n_fail = 0;
    int exp_urc = 0;

    always #4 clk = ~clk;

    tlb_unit dut (.*);

    typedef struct packed {
        logic [31:0] a;
        logic        sv;
        logic        md;
        logic [7:0]  as;
        logic [2:0]  res;   // {hit,miss,multi}
        logic [5:0]  idx;
        logic [28:0] pa;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{32'h0001_0ABC, 1'b0, 1'b1, 8'd5, 3'b100, 6'd0, 29'h0234_5ABC}, // R3 4K page
        '{32'h0001_0ABC, 1'b0, 1'b1, 8'd6, 3'b010, 6'd0, 29'h0},          // R2 tag mismatch
        '{32'h0001_0ABC, 1'b1, 1'b1, 8'd6, 3'b100, 6'd0, 29'h0234_5ABC}, // R2 bypass
        '{32'h0001_0ABC, 1'b1, 1'b0, 8'd6, 3'b010, 6'd0, 29'h0},          // R2 user mode checks
        '{32'h0045_6789, 1'b0, 1'b1, 8'd3, 3'b100, 6'd1, 29'h1235_6789}, // R2 shared, R3 1M
        '{32'h0080_03FF, 1'b0, 1'b1, 8'd5, 3'b100, 6'd2, 29'h0000_07FF}, // R3 1K top
        '{32'h0080_0400, 1'b0, 1'b1, 8'd5, 3'b010, 6'd0, 29'h0},          // R3 past 1K
        '{32'h00A0_FFFE, 1'b0, 1'b1, 8'd5, 3'b100, 6'd3, 29'h0555_FFFE}, // R3 64K
        '{32'h00A1_0000, 1'b0, 1'b1, 8'd5, 3'b010, 6'd0, 29'h0},          // R3 past 64K
        '{32'h0100_0800, 1'b0, 1'b1, 8'd5, 3'b001, 6'd0, 29'h0},          // R4 overlap
        '{32'h0100_F000, 1'b0, 1'b1, 8'd5, 3'b100, 6'd5, 29'h0666_F000}, // R4 single of pair
        '{32'h0200_0010, 1'b0, 1'b1, 8'd5, 3'b010, 6'd0, 29'h0}           // R1 invalid entry
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int urc_next(int u);
        int n = u + 1;
        if ((urb != 0 && n > int'(urb)) || n > 63) return 0;
        return n;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic d_look(input logic [31:0] a, input logic sv, input logic md,
                          input logic [7:0] as, input logic [2:0] res,
                          input logic [5:0] idx, input logic [28:0] pa,
                          input string tag, input bit do_chk);
        d_req = 1'b1; d_addr = a; cfg_sv = sv; cfg_md = md; cur_asid = as;
        #2;
        if (do_chk) begin
            chk(tag, {d_hit, d_miss, d_multi}, res);
            if (res == 3'b100) begin
                chk(tag, d_idx, idx);
                chk(tag, d_paddr, pa);
            end
        end
        tick();
        d_req = 1'b0;
        exp_urc = urc_next(exp_urc);
    endtask

    task automatic bump();
        d_look(32'hF000_0000, 1'b0, 1'b1, 8'd0, 3'b010, 6'd0, 29'h0, "", 1'b0);
    endtask

    task automatic load(input logic [21:0] vpn, input logic [7:0] as, input logic [18:0] ppn,
                        input logic [1:0] sz, input logic sh, input logic v, input logic [3:0] at);
        load_en = 1'b1; load_vpn = vpn; load_asid = as; load_ppn = ppn;
        load_sz = sz; load_sh = sh; load_v = v; load_attr = at;
        tick();
        load_en = 1'b0;
        bump();
    endtask

    task automatic i_look(input logic [31:0] a, input logic e_hit, input logic e_fill,
                          input logic [1:0] e_idx, input logic [28:0] e_pa,
                          input logic [5:0] e_lru);
        i_req = 1'b1; i_addr = a;
        #2;
        chk("R5 i_hit", i_hit, e_hit);
        chk("R5 i_fill", i_fill, e_fill);
        chk("R6 i_idx", i_idx, e_idx);
        chk("R5 i_paddr", i_paddr, e_pa);
        tick();
        i_req = 1'b0;
        if (!e_hit) exp_urc = urc_next(exp_urc);
        chk("R7 lru", lru, e_lru);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; inv_all = 1'b0; cfg_sv = 1'b0; cfg_md = 1'b1; cur_asid = 8'd0;
        urb = 6'd0; load_en = 1'b0; load_vpn = '0; load_asid = '0; load_ppn = '0;
        load_sz = '0; load_sh = 1'b0; load_v = 1'b0; load_attr = '0;
        d_req = 1'b0; d_addr = '0; i_req = 1'b0; i_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        chk("R1 reset urc", urc, 6'd0);
        chk("R1 reset lru", lru, 6'd0);
        d_look(32'h0001_0ABC, 1'b0, 1'b1, 8'd5, 3'b010, 6'd0, 29'h0, "R1 empty miss", 1'b1);
        chk("R8 urc step", urc, 6'd1);
        rst_n = 1'b0; tick(); rst_n = 1'b1; exp_urc = 0;
        chk("R1 reset urc again", urc, 6'd0);

        // unified entries 0..11, each load followed by a search to step urc (R9)
        load(22'h00040, 8'd5, 19'h08D14, 2'd1, 1'b0, 1'b1, 4'h1);
        load(22'h01000, 8'd9, 19'h48C00, 2'd3, 1'b1, 1'b1, 4'h2);
        load(22'h02000, 8'd5, 19'h00001, 2'd0, 1'b0, 1'b1, 4'h3);
        load(22'h02800, 8'd5, 19'h15540, 2'd2, 1'b0, 1'b1, 4'h4);
        load(22'h04000, 8'd5, 19'h00100, 2'd1, 1'b0, 1'b1, 4'h5);
        load(22'h04000, 8'd5, 19'h19980, 2'd2, 1'b0, 1'b1, 4'h6);
        load(22'h08000, 8'd5, 19'h00200, 2'd1, 1'b0, 1'b0, 4'h7);
        for (int k = 1; k <= 5; k++)
            load(22'h40000 + 22'(k - 1) * 22'h04000, 8'd0, 19'(k * 32'h400), 2'd1, 1'b1, 1'b1, 4'(k));
        chk("R8 urc after loads", urc, 6'(exp_urc));

        // table of data lookups: R1 R2 R3 R4
        for (int v = 0; v < 12; v++)
            d_look(VEC[v].a, VEC[v].sv, VEC[v].md, VEC[v].as, VEC[v].res, VEC[v].idx,
                   VEC[v].pa, $sformatf("vec%0d R1/R2/R3/R4", v), 1'b1);
        chk("R8 urc after table", urc, 6'(exp_urc));

        // instruction side fills and LRU order: R5 R6 R7
        i_look(32'h1000_0123, 1'b0, 1'b1, 2'd3, 29'h0010_0123, 6'b001011);
        i_look(32'h1000_0123, 1'b1, 1'b0, 2'd3, 29'h0010_0123, 6'b001011);
        i_look(32'h1100_0040, 1'b0, 1'b1, 2'd2, 29'h0020_0040, 6'b011110);
        i_look(32'h1200_0000, 1'b0, 1'b1, 2'd1, 29'h0030_0000, 6'b111000);
        i_look(32'h1300_0000, 1'b0, 1'b1, 2'd0, 29'h0040_0000, 6'b000000);
        i_look(32'h1000_0123, 1'b1, 1'b0, 2'd3, 29'h0010_0123, 6'b001011);
        i_look(32'h1400_0000, 1'b0, 1'b1, 2'd2, 29'h0050_0000, 6'b011110);
        i_look(32'h1100_0040, 1'b0, 1'b1, 2'd1, 29'h0020_0040, 6'b111000);
        i_look(32'h1300_0000, 1'b1, 1'b0, 2'd0, 29'h0040_0000, 6'b000000);
        chk("R8 urc after fills", urc, 6'(exp_urc));

        // R8 wrap at a nonzero bound
        urb = 6'd3;
        bump(); chk("R8 wrap to bound", urc, 6'd0);
        bump(); chk("R8 bound step1", urc, 6'd1);
        bump(); bump(); chk("R8 at bound", urc, 6'd3);
        bump(); chk("R8 past bound", urc, 6'd0);
        urb = 6'd0;
        while (exp_urc != 63) bump();
        chk("R8 top", urc, 6'd63);
        bump(); chk("R8 natural wrap", urc, 6'd0);

        // R9 load overwrites the slot at urc (slot 0)
        load(22'h0C0000, 8'd5, 19'h1DDDC, 2'd1, 1'b0, 1'b1, 4'h9);
        d_look(32'h3000_0010, 1'b0, 1'b1, 8'd5, 3'b100, 6'd0, 29'h0777_7010, "R9 new entry", 1'b1);
        d_look(32'h0001_0ABC, 1'b0, 1'b1, 8'd5, 3'b010, 6'd0, 29'h0, "R9 old entry gone", 1'b1);

        // R10 invalidate with a simultaneous load
        inv_all = 1'b1; load_en = 1'b1; load_vpn = 22'h0C4000; load_asid = 8'd5;
        load_ppn = 19'h00300; load_sz = 2'd1; load_sh = 1'b0; load_v = 1'b1;
        tick();
        inv_all = 1'b0; load_en = 1'b0;
        d_look(32'h3000_0010, 1'b0, 1'b1, 8'd5, 3'b010, 6'd0, 29'h0, "R10 cleared", 1'b1);
        d_look(32'h3100_0000, 1'b0, 1'b1, 8'd5, 3'b010, 6'd0, 29'h0, "R10 load dropped", 1'b1);
        i_req = 1'b1; i_addr = 32'h1000_0123;
        #2;
        chk("R10 i_miss", i_miss, 1'b1);
        chk("R10 no fill", i_fill, 1'b0);
        tick();
        i_req = 1'b0;
        chk("R10 lru kept", lru, 6'b000000);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule